// File: doc/BRIEF.md
# Real-Time-Clock Register Port with Flag-Driven Interrupt

This block is the host-facing register file of a real-time clock. It sits on a byte bus with two addresses: an access to the even address selects one of 128 byte locations, and an access to the odd address reads or writes the location that is selected. Four locations are control and status registers: a rate/divider register, a mode/enable register, an event-flag register and a fixed status register. All other locations are plain byte storage for time fields and non-volatile configuration bytes.

The time engine, the alarm comparator and the periodic rate generator sit outside this block. Each one reports an event through a one-cycle strobe. Each strobe sets its flag whether or not its enable is on. The interrupt output is a level that follows the summary flag in bit 7 of the flag register. It rises when a flag goes from 0 to 1 while its enable is on, or at once when an enable is turned on while its flag is already set. Software clears all flags and drops the line by reading the flag register.

Top module: `rtc_regport`

## Requirements
- R1: A write to the even address latches data bits 6:0 as the index. A read of the even address returns 0xFF.
- R2: Odd-address accesses read and write the indexed byte. Indexes 0x00–0x09 and 0x0E–0x7F are plain storage that returns the last byte written.
- R3: While reset is held and after it, the rate register reads 0x26, the mode register 0x02, the flag register 0x00 and the status register 0x80, and `irq` is low. Storage byte 0x0F is cleared by reset unless it holds 0xFE. Other storage bytes keep their contents through reset.
- R4: In the rate register (index 0x0A), bit 7 is read-only and shows `upd_busy` as sampled at the previous clock edge. A write stores only bits 6:0.
- R5: Writes to the flag register (0x0C) and the status register (0x0D) have no effect.
- R6: `tick_periodic` sets flag bit 6, `tick_alarm` sets bit 5 and `tick_update` sets bit 4. This happens whatever the enables are.
- R7: The summary bit (flag bit 7) and `irq` go high one cycle after a strobe that takes a flag from 0 to 1 while its enable is set. The enables are mode-register bits 6, 5 and 4, matching the flag positions. `irq` always equals the summary bit.
- R8: A read of the flag register returns its current contents and then clears all of its bits, and `irq` is low in the next cycle. A strobe that arrives in the same cycle as the read is kept as a new flag after the clear.
- R9: After a mode-register write, the summary bit and `irq` are 1 if (new enables AND flags) is non-zero, and 0 otherwise. Strobes in the same cycle count as flags.
- R10: A mode-register write with bit 7 (set mode) at 1 stores bit 4 as 0.

Ports are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_en | input | 1 | Bus access strobe for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_odd | input | 1 | 1 = data address, 0 = index address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| tick_periodic | input | 1 | Periodic rate event strobe |
| tick_alarm | input | 1 | Alarm match strobe |
| tick_update | input | 1 | Update-ended strobe |
| upd_busy | input | 1 | Update-in-progress level from the time engine |
| irq | output | 1 | Interrupt level |

## Verification
Two functions can land on the same clock edge: an event strobe and a host access to the flag or mode register. The bench asserts `tick_periodic` in the same cycle as a flag-register read. It checks that the read returns the old contents and that the new flag and `irq` are present afterwards. It also asserts `tick_alarm` in the same cycle as a mode-register write that enables alarms, and expects `irq` to be high after that edge. Exhaustive sweeps over all enable and strobe combinations compute the expected flag byte and line level arithmetically.

// File: rtl/rtc_regport.sv
module rtc_regport #(
  parameter int IDX_W = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_en,
  input  logic       bus_wr,
  input  logic       bus_odd,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       tick_periodic,
  input  logic       tick_alarm,
  input  logic       tick_update,
  input  logic       upd_busy,
  output logic       irq
);
  localparam int DEPTH = 1 << IDX_W;
  localparam logic [IDX_W-1:0] IX_A    = IDX_W'(10);
  localparam logic [IDX_W-1:0] IX_B    = IDX_W'(11);
  localparam logic [IDX_W-1:0] IX_C    = IDX_W'(12);
  localparam logic [IDX_W-1:0] IX_D    = IDX_W'(13);
  localparam logic [IDX_W-1:0] IX_SHUT = IDX_W'(15);
  localparam logic [7:0] D_VAL = 8'h80;

  logic [IDX_W-1:0] idx;
  logic [7:0]       ram [DEPTH];
  logic [6:0]       reg_a;
  logic             uip;
  logic [7:0]       reg_b;
  logic [7:0]       reg_c;

  wire odd_wr = bus_en & bus_wr & bus_odd;
  wire odd_rd = bus_en & ~bus_wr & bus_odd;
  wire idx_wr = bus_en & bus_wr & ~bus_odd;
  wire wr_a   = odd_wr & (idx == IX_A);
  wire wr_b   = odd_wr & (idx == IX_B);
  wire rd_c   = odd_rd & (idx == IX_C);
  wire is_ram = (idx < IX_A) || (idx > IX_D);

  wire [2:0] ev      = {tick_periodic, tick_alarm, tick_update};
  wire [7:0] b_wval  = {bus_wdata[7:5], bus_wdata[4] & ~bus_wdata[7], bus_wdata[3:0]};
  wire [2:0] fl_base = rd_c ? 3'b000 : reg_c[6:4];
  wire [2:0] fl_next = fl_base | ev;
  wire [2:0] rise    = ev & ~fl_base;
  wire       sum_old = rd_c ? 1'b0 : reg_c[7];
  wire       sum_next = wr_b ? |(b_wval[6:4] & fl_next)
                             : (sum_old | |(rise & reg_b[6:4]));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx   <= '0;
      reg_a <= 7'h26;
      uip   <= 1'b0;
      reg_b <= 8'h02;
      reg_c <= 8'h00;
    end else begin
      uip <= upd_busy;
      if (idx_wr) idx <= bus_wdata[IDX_W-1:0];
      if (wr_a)   reg_a <= bus_wdata[6:0];
      if (wr_b)   reg_b <= b_wval;
      reg_c <= {sum_next, fl_next, 4'b0000};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      if (ram[IX_SHUT] != 8'hFE) ram[IX_SHUT] <= 8'h00;
    end else if (odd_wr && is_ram) begin
      ram[idx] <= bus_wdata;
    end
  end

  always_comb begin
    if (!bus_odd) bus_rdata = 8'hFF;
    else begin
      case (idx)
        IX_A:    bus_rdata = {uip, reg_a};
        IX_B:    bus_rdata = reg_b;
        IX_C:    bus_rdata = reg_c;
        IX_D:    bus_rdata = D_VAL;
        default: bus_rdata = ram[idx];
      endcase
    end
  end

  assign irq = reg_c[7];

  assert_read_drops_line_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_c && ev == 3'b000) |=> !irq);

  assert_flags_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_c |=> ((reg_c[6:4] & $past(reg_c[6:4])) == $past(reg_c[6:4])));

  assert_periodic_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tick_periodic |=> reg_c[6]);

  assert_enabled_event_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_alarm && reg_b[5] && !wr_b) |=> irq);

  assert_set_clears_uie_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_b && bus_wdata[7]) |=> !reg_b[4]);

  assert_flag_write_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (odd_wr && idx == IX_C && ev == 3'b000) |=> $stable(reg_c));
endmodule

// File: tb/rtc_regport_test.sv
module rtc_regport_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_en = 1'b0, bus_wr = 1'b0, bus_odd = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic tick_periodic = 1'b0, tick_alarm = 1'b0, tick_update = 1'b0;
  logic upd_busy = 1'b0;
  logic irq;
  int vectors = 0;
  int misses = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rtc_regport uut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr), .bus_odd(bus_odd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_periodic(tick_periodic),
    .tick_alarm(tick_alarm), .tick_update(tick_update), .upd_busy(upd_busy), .irq(irq)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic odd, input logic wr, input logic [7:0] d,
                     input logic [2:0] t, output logic [7:0] q);
    bus_en = 1'b1; bus_odd = odd; bus_wr = wr; bus_wdata = d;
    {tick_periodic, tick_alarm, tick_update} = t;
    #1 q = bus_rdata;
    @(posedge clk); #1;
    bus_en = 1'b0; bus_wr = 1'b0; {tick_periodic, tick_alarm, tick_update} = 3'b000;
  endtask

  task automatic wr_reg(input logic [7:0] i, input logic [7:0] d);
    logic [7:0] q;
    acc(1'b0, 1'b1, i, 3'b000, q);
    acc(1'b1, 1'b1, d, 3'b000, q);
  endtask

  task automatic rd_reg(input logic [7:0] i, output logic [7:0] q);
    logic [7:0] x;
    acc(1'b0, 1'b1, i, 3'b000, x);
    acc(1'b1, 1'b0, 8'h00, 3'b000, q);
  endtask

  task automatic pulse(input logic [2:0] t);
    {tick_periodic, tick_alarm, tick_update} = t;
    @(posedge clk); #1;
    {tick_periodic, tick_alarm, tick_update} = 3'b000;
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic summary;
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  endtask

  initial begin
    #400000;
    misses++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
  end

  initial begin
    logic [7:0] q;
    do_reset();
    // R3 reset state
    rd_reg(8'h0A, q); check("R3 reg A", q, 8'h26);
    rd_reg(8'h0B, q); check("R3 reg B", q, 8'h02);
    rd_reg(8'h0C, q); check("R3 reg C", q, 8'h00);
    rd_reg(8'h0D, q); check("R3 reg D", q, 8'h80);
    check("R3 irq low", {7'd0, irq}, 8'h00);

    // R1 even read
    acc(1'b0, 1'b0, 8'h00, 3'b000, q); check("R1 even read", q, 8'hFF);
    // R1 index uses only bits 6:0
    wr_reg(8'h20, 8'h3C);
    wr_reg(8'hA0, 8'h77);
    rd_reg(8'h20, q); check("R1 index bit7 dropped", q, 8'h77);

    // R2 storage sweep
    for (int i = 0; i < 128; i++)
      if (i < 10 || i > 13) wr_reg(8'(i), 8'(i) ^ 8'h5A);
    for (int i = 0; i < 128; i++)
      if (i < 10 || i > 13) begin
        rd_reg(8'(i), q); check("R2 storage readback", q, 8'(i) ^ 8'h5A);
      end

    // R3 byte 0x0F and non-volatile bytes across reset
    wr_reg(8'h0F, 8'hFE); wr_reg(8'h30, 8'hC3);
    do_reset();
    rd_reg(8'h0F, q); check("R3 0x0F kept when FE", q, 8'hFE);
    rd_reg(8'h30, q); check("R3 storage kept", q, 8'hC3);
    wr_reg(8'h0F, 8'h33);
    do_reset();
    rd_reg(8'h0F, q); check("R3 0x0F cleared", q, 8'h00);

    // R4 UIP read-only
    upd_busy = 1'b1; @(posedge clk); #1;
    rd_reg(8'h0A, q); check("R4 uip shows busy", q, 8'hA6);
    upd_busy = 1'b0;
    wr_reg(8'h0A, 8'hFF);
    rd_reg(8'h0A, q); check("R4 write keeps bit7 from busy", q, 8'h7F);
    upd_busy = 1'b1;
    wr_reg(8'h0A, 8'h00);
    rd_reg(8'h0A, q); check("R4 write cannot clear uip", q, 8'h80);
    upd_busy = 1'b0;

    // R5 writes to C and D ignored
    wr_reg(8'h0B, 8'h02);
    pulse(3'b100);
    wr_reg(8'h0C, 8'h00);
    wr_reg(8'h0D, 8'h00);
    rd_reg(8'h0D, q); check("R5 D write ignored", q, 8'h80);
    rd_reg(8'h0C, q); check("R5 C write ignored", q, 8'h40);

    // R6 R7 R8 sweep over enables x strobes
    for (int e = 0; e < 8; e++)
      for (int t = 0; t < 8; t++) begin
        logic [2:0] en = 3'(e);
        logic [2:0] tk = 3'(t);
        logic exp_i = |(en & tk);
        wr_reg(8'h0B, {1'b0, en, 4'h2});
        rd_reg(8'h0C, q);
        pulse(tk);
        check("R7 irq after strobe", {7'd0, irq}, {7'd0, exp_i});
        rd_reg(8'h0C, q); check("R6 R7 flag byte", q, {exp_i, tk, 4'h0});
        check("R8 irq low after read", {7'd0, irq}, 8'h00);
        rd_reg(8'h0C, q); check("R8 flags cleared", q, 8'h00);
      end

    // R9 enable write with flags already set
    for (int f = 0; f < 8; f++)
      for (int e = 0; e < 8; e++) begin
        logic [2:0] fl = 3'(f);
        logic [2:0] en = 3'(e);
        logic exp_i = |(en & fl);
        wr_reg(8'h0B, 8'h02);
        rd_reg(8'h0C, q);
        pulse(fl);
        check("R7 no irq while disabled", {7'd0, irq}, 8'h00);
        wr_reg(8'h0B, {1'b0, en, 4'h2});
        check("R9 irq after enable write", {7'd0, irq}, {7'd0, exp_i});
        rd_reg(8'h0C, q); check("R9 flag byte", q, {exp_i, fl, 4'h0});
      end

    // R9 disabling drops line while flag stays
    wr_reg(8'h0B, 8'h22); rd_reg(8'h0C, q);
    pulse(3'b010);
    check("R9 alarm irq", {7'd0, irq}, 8'h01);
    wr_reg(8'h0B, 8'h02);
    check("R9 disable lowers irq", {7'd0, irq}, 8'h00);
    rd_reg(8'h0C, q); check("R9 flag kept without summary", q, 8'h20);

    // R10 set mode forces bit4 clear
    wr_reg(8'h0B, 8'h90); rd_reg(8'h0B, q); check("R10 set clears bit4", q, 8'h80);
    wr_reg(8'h0B, 8'h10); rd_reg(8'h0B, q); check("R10 bit4 kept", q, 8'h10);

    // R8 strobe in same cycle as flag read
    wr_reg(8'h0B, 8'h42); rd_reg(8'h0C, q);
    pulse(3'b100);
    acc(1'b0, 1'b1, 8'h0C, 3'b000, q);
    acc(1'b1, 1'b0, 8'h00, 3'b100, q); check("R8 read returns old", q, 8'hC0);
    check("R8 same-cycle strobe raises irq", {7'd0, irq}, 8'h01);
    rd_reg(8'h0C, q); check("R8 same-cycle flag kept", q, 8'hC0);
    check("R8 irq low", {7'd0, irq}, 8'h00);

    // R9 strobe in same cycle as enabling write
    wr_reg(8'h0B, 8'h02); rd_reg(8'h0C, q);
    acc(1'b0, 1'b1, 8'h0B, 3'b000, q);
    acc(1'b1, 1'b1, 8'h22, 3'b010, q);
    check("R9 same-cycle enable and strobe", {7'd0, irq}, 8'h01);
    rd_reg(8'h0C, q); check("R9 same-cycle flag byte", q, 8'hA0);

    summary();
  end
endmodule